// File: doc/BRIEF.md
# NPC Phase-Leg Delayed Trip Sequencer

This block sits between a PWM generator and the four gate drivers of one phase leg of a three-level neutral-point-clamped inverter. It passes the four raw gate commands through unchanged in normal running. When the active-low fault line drops, it blanks the gates in a safe order. The two outer switches and the inner switch that is currently switching are cut in the same cycle. The inner switch that is holding the leg on its clamp path is cut only after a programmable number of clocks.

A half-cycle polarity input tells the block which inner switch is the conducting one. In the positive half, S1 and S3 alternate, S2 is held on and S4 is off. In the negative half, S2 and S4 alternate, S3 is held on and S1 is off. When the fault line returns high, the held inner switch is released in that same cycle and the outer switches follow one clock later, so the inner device always turns on first. Faults shorter than the delay never touch the held inner switch. Faults lasting many PWM periods keep it off until the fault clears.

Top module: `npc_trip_seq`

## Requirements
- R1: Gate bit order on both the command and output vectors is bit0 = S1 (upper outer), bit1 = S2 (upper inner), bit2 = S3 (lower inner), bit3 = S4 (lower outer). After a synchronous reset, while the fault line is high, every output equals its command.
- R2: In any cycle where the fault line is low, outputs S1 and S4 are 0 in that same cycle, with no register in the path.
- R3: With polarity 0 (positive half), S2 is the held inner switch and S3 is blanked at once together with the outer switches. With polarity 1 (negative half), S3 is the held inner switch and S2 is blanked at once.
- R4: With a delay value D of 1 or more, the held inner output follows its command for the first D cycles of a fault (cycles 0 to D-1, counted from the first cycle the fault line is low) and is 0 from cycle D. A delay value of 0 acts as 1.
- R5: A fault that clears before the delay runs out never blanks the held inner switch.
- R6: In the first cycle the fault line is back high, the held inner output follows its command while S1, S4 and the switching inner output are still 0. From the next cycle, all outputs follow their commands.
- R7: The delay value is captured only on clock edges where the fault line is high. A change made while a fault is in progress does not alter that fault's timing. It applies from the next fault.
- R8: The delay counter is held at zero while the fault line is high and stops at the delay value. It never wraps, so a fault of any length keeps the held inner switch off until the fault clears.
- R9: Every fault is timed from zero, regardless of earlier faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_cmd_i | input | 4 | Raw gate commands (bit0 S1, bit1 S2, bit2 S3, bit3 S4) |
| half_neg_i | input | 1 | Polarity: 0 = positive half cycle, 1 = negative half cycle |
| trip_n_i | input | 1 | Fault line, active low, synchronous to clk |
| delay_i | input | DELAY_W (16) | Inner turn-off delay in clocks |
| gate_out_o | output | 4 | Protected gate outputs, same bit order as gate_cmd_i |

## Verification
On every cycle, the assertions check four things. The outer gates are dead whenever the fault line is low. The counter sits at zero while the line is high and never passes the captured delay. A cleared enable bit cannot come back while the fault persists. The recovery cycle re-enables the inner path before the outer path. Other behaviour can only be shown by the directed scenarios:
- the exact cycle at which the held inner gate drops for a given delay;
- the polarity swap of which inner gate is held;
- the fact that a delay written during a fault is ignored until the next fault;
- the retiming from zero on back-to-back faults.

// File: rtl/npc_trip_pkg.sv
// Package: shared constants for the NPC trip sequencer.
// Holds the gate bit positions and the role each gate plays in the shutdown
// order. Assumes one phase leg with exactly four series switches.
package npc_trip_pkg;

    localparam int NUM_GATES = 4;

    localparam int GATE_S1 = 0;   // upper outer
    localparam int GATE_S2 = 1;   // upper inner
    localparam int GATE_S3 = 2;   // lower inner
    localparam int GATE_S4 = 3;   // lower outer

    typedef enum logic [1:0] {
        ROLE_OUTER    = 2'd0,
        ROLE_INNER_HI = 2'd1,
        ROLE_INNER_LO = 2'd2
    } gate_role_e;

    // Returns the shutdown role of a gate index.
    function automatic gate_role_e role_of(input int idx);
        if (idx == GATE_S2) begin
            return ROLE_INNER_HI;
        end else if (idx == GATE_S3) begin
            return ROLE_INNER_LO;
        end
        return ROLE_OUTER;
    endfunction

endpackage

// File: rtl/npc_trip_edge.sv
// Module: npc_trip_edge
// Tracks the previous fault-line level. From it, the module derives the
// one-cycle recovery pulse and the outer-path enable. The outer enable is
// low in any fault cycle and in the first cycle after the fault clears.
// Assumes trip_n_i is already synchronous to clk.
module npc_trip_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_n_i,
    output logic rise_o,
    output logic outer_en_o
);

    logic trip_n_q;

    // Remember last cycle's fault-line level (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_n_q <= 1'b1;
        end else begin
            trip_n_q <= trip_n_i;
        end
    end

    // Recovery pulse and the delayed re-enable of the outer path.
    always_comb begin
        rise_o     = trip_n_i & ~trip_n_q;
        outer_en_o = trip_n_i & trip_n_q;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);                                       // R6

endmodule

// File: rtl/npc_delay_cnt.sv
// Module: npc_delay_cnt
// Captures the delay value while the fault line is high. Counts clocks while
// the line is low, stopping at the captured value, and flags when the
// enable bit should be cleared on the next edge. A zero delay acts as one.
module npc_delay_cnt #(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trip_n_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               match_o
);

    localparam int CMP_W = DELAY_W + 1;

    logic [DELAY_W-1:0] delay_q;
    logic [DELAY_W-1:0] cnt_q;
    logic [CMP_W-1:0]   cnt_plus;

    // Capture the delay only between faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q <= '0;
        end else if (trip_n_i) begin
            delay_q <= delay_i;
        end
    end

    // Count fault cycles, cleared while idle, saturating at the delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trip_n_i) begin
            cnt_q <= '0;
        end else if (cnt_q != delay_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Match when the next edge will complete the programmed delay.
    always_comb begin
        cnt_plus = {1'b0, cnt_q} + CMP_W'(1);
        match_o  = ~trip_n_i & (cnt_plus >= {1'b0, delay_q});
    end

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trip_n_i |=> (cnt_q == '0));                               // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= delay_q);                                         // R8

    AST_DELAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n_i |=> $stable(delay_q));                           // R7

endmodule

// File: rtl/npc_inner_state.sv
// Module: npc_inner_state
// Holds the inner-path enable bit. The delay match clears it and the
// recovery pulse sets it. The output ORs in the recovery pulse so the held
// inner switch comes back in the same cycle the fault clears.
module npc_inner_state (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic rise_i,
    input  logic trip_n_i,
    output logic inner_en_o
);

    logic en_q;

    // Set on recovery, clear on delay match, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (rise_i) begin
            en_q <= 1'b1;
        end else if (match_i) begin
            en_q <= 1'b0;
        end
    end

    // Combine the stored bit with the same-cycle recovery pulse.
    always_comb begin
        inner_en_o = en_q | rise_i;
    end

    AST_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !trip_n_i) |=> !en_q);                           // R8

endmodule

// File: rtl/npc_gate_mask.sv
// Module: npc_gate_mask
// Gates each raw command with the enable that fits its role. Outer gates
// always use the outer enable. The inner gate that is held on in the
// present half cycle uses the delayed inner enable. The other inner gate is
// treated like an outer gate.
module npc_gate_mask
    import npc_trip_pkg::*;
(
    input  logic                 half_neg_i,
    input  logic                 outer_en_i,
    input  logic                 inner_en_i,
    input  logic [NUM_GATES-1:0] cmd_i,
    output logic [NUM_GATES-1:0] out_o
);

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        if (role_of(g) == ROLE_INNER_HI) begin : g_inner_hi
            // Upper inner is held on in the positive half.
            always_comb out_o[g] = cmd_i[g] & (half_neg_i ? outer_en_i : inner_en_i);
        end else if (role_of(g) == ROLE_INNER_LO) begin : g_inner_lo
            // Lower inner is held on in the negative half.
            always_comb out_o[g] = cmd_i[g] & (half_neg_i ? inner_en_i : outer_en_i);
        end else begin : g_outer
            // Outer switches are cut immediately.
            always_comb out_o[g] = cmd_i[g] & outer_en_i;
        end
    end

endmodule

// File: rtl/npc_trip_seq.sv
// Module: npc_trip_seq (top)
// Delayed trip sequencer for one NPC phase leg. Outer and switching-inner
// gates drop in the fault cycle. The held inner gate drops after delay_i
// clocks. On recovery the held inner gate returns first and the rest one
// clock later. Assumes trip_n_i and half_neg_i are synchronous to clk.
module npc_trip_seq
    import npc_trip_pkg::*;
#(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         gate_cmd_i,
    input  logic               half_neg_i,
    input  logic               trip_n_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic [3:0]         gate_out_o
);

    logic rise;
    logic outer_en;
    logic match;
    logic inner_en;

    npc_trip_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_n_i   (trip_n_i),
        .rise_o     (rise),
        .outer_en_o (outer_en)
    );

    npc_delay_cnt #(.DELAY_W(DELAY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_n_i (trip_n_i),
        .delay_i  (delay_i),
        .match_o  (match)
    );

    npc_inner_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_i    (match),
        .rise_i     (rise),
        .trip_n_i   (trip_n_i),
        .inner_en_o (inner_en)
    );

    npc_gate_mask u_mask (
        .half_neg_i (half_neg_i),
        .outer_en_i (outer_en),
        .inner_en_i (inner_en),
        .cmd_i      (gate_cmd_i),
        .out_o      (gate_out_o)
    );

    AST_OUTER_DEAD_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n_i |-> (gate_out_o[GATE_S1] == 1'b0 && gate_out_o[GATE_S4] == 1'b0)); // R2

    AST_INNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_n_i) |-> (inner_en && !outer_en));             // R6

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_n_i && $past(trip_n_i)) |-> (gate_out_o == gate_cmd_i)); // R1

endmodule

// File: tb/sim_npc_trip_seq.sv
module sim_npc_trip_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    gate_cmd_i = 4'h0;
    logic          half_neg_i = 1'b0;
    logic          trip_n_i = 1'b1;
    logic [DW-1:0] delay_i = '0;
    logic [3:0]    gate_out_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    npc_trip_seq #(.DELAY_W(DW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_cmd_i (gate_cmd_i),
        .half_neg_i (half_neg_i),
        .trip_n_i   (trip_n_i),
        .delay_i    (delay_i),
        .gate_out_o (gate_out_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance to just after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        #2;
        checks++;
        if (gate_out_o !== exp) begin
            failures++;
            $display("FAIL %s: gate_out actual=%b expected=%b at %0t", req, gate_out_o, exp, $time);
        end
    endtask

    // Expected outputs in a fault with all commands high: held inner only.
    function automatic logic [3:0] held_mask(input logic neg, input bit on);
        if (!on) return 4'b0000;
        return neg ? 4'b0100 : 4'b0010;
    endfunction

    // R1: reset state and pass-through in normal running.
    task automatic t_reset();
        gate_cmd_i = 4'b1011;
        trip_n_i   = 1'b1;
        rst_n      = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 reset pass", 4'b1011);
        gate_cmd_i = 4'b0101;
        check("R1 pattern", 4'b0101);
        gate_cmd_i = 4'b0010;
        half_neg_i = 1'b1;
        check("R1 neg pattern", 4'b0010);
        half_neg_i = 1'b0;
    endtask

    // One fault of len cycles with delay d (R2,R3,R4,R5,R6); optional delay change mid-fault (R7).
    task automatic t_fault(input logic neg, input int d, input int len,
                           input bit chg, input int d_new, input string tag);
        int eff;
        eff = (d == 0) ? 1 : d;
        gate_cmd_i = 4'hF;
        half_neg_i = neg;
        delay_i    = DW'(d);
        step();
        step();
        for (int c = 0; c < len; c++) begin
            step();
            if (c == 0) begin
                trip_n_i = 1'b0;
                if (chg) delay_i = DW'(d_new);
            end
            check({tag, " R2 R3 R4 fault cycle"}, held_mask(neg, c < eff));
        end
        step();
        trip_n_i = 1'b1;
        check({tag, " R6 inner first"}, held_mask(neg, 1'b1));
        step();
        check({tag, " R6 all back"}, 4'hF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fault(1'b0, 5, 9, 1'b0, 0, "R4 pos d5");
        t_fault(1'b1, 5, 9, 1'b0, 0, "R3 neg d5");
        t_fault(1'b0, 1, 4, 1'b0, 0, "R4 d1");
        t_fault(1'b0, 0, 4, 1'b0, 0, "R4 d0");
        t_fault(1'b1, 8, 5, 1'b0, 0, "R5 short");
        t_fault(1'b0, 6, 10, 1'b1, 2, "R7 change ignored");
        t_fault(1'b0, 2, 5, 1'b0, 0, "R7 new applies");
        t_fault(1'b1, 3, 300, 1'b0, 0, "R8 long");
        t_fault(1'b0, 4, 7, 1'b0, 0, "R9 first");
        t_fault(1'b0, 4, 7, 1'b0, 0, "R9 second");
        // R2: outer dead with sparse commands, positive half, switching inner S3 also cut.
        gate_cmd_i = 4'b1101;
        delay_i    = DW'(3);
        step();
        step();
        trip_n_i = 1'b0;
        check("R2 R3 sparse cmd", 4'b0000);
        gate_cmd_i = 4'b0010;
        check("R3 held S2 follows cmd", 4'b0010);
        step();
        trip_n_i = 1'b1;
        step();
        step();
        check("R1 idle after", 4'b0010);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule